// File: doc/BRIEF.md
# Virtual Channel Router Input Unit

This block is one input port of a wormhole router that multiplexes several virtual channels over a single physical link. Each arriving flit carries a virtual channel number and a two-bit type. It lands in that channel's own queue. A small state machine per channel walks the packet at the queue front through the router pipeline. A head flit gets a route from dimension-ordered XY routing on the destination coordinates it carries. It then requests a downstream virtual channel from an external VC allocator, and only after that competes for the switch. Body and tail flits inherit the stored route and output channel, so they enter switch allocation directly.

A flit may request the switch only while the downstream buffer of its output virtual channel holds at least one free slot. The unit keeps one credit counter for every output port and output VC pair. A counter drops by one for each forwarded flit and rises by one for each returned credit pulse. An external switch allocator grants at most one channel per cycle. The granted flit is registered into a traversal stage that feeds the crossbar. When a tail traverses, a release pulse frees the downstream VC and the input channel goes back to idle, ready for the next head.

Top module: `vc_input_unit`

## Requirements
- R1: A head flit written in cycle 0 raises its VC allocation request in cycle 2 and its switch request in cycle 3 (given grants), and appears on the crossbar output in cycle 4: routing, VC allocation, switch allocation and traversal take one cycle each.
- R2: Flit type codes are 00 body, 01 head, 10 tail and 11 single-flit packet. Bit 0 marks a head and bit 1 marks a tail. Only flits with bit 0 set cause a VC allocation request; body and tail flits reuse the stored route and output VC.
- R3: Flits of one input VC leave in arrival order, with no overtaking. Flits of different VCs may interleave on the output.
- R4: While a head waits for its VC grant, its allocation request stays high, no switch request is raised for that VC and nothing is forwarded from it.
- R5: A VC raises no switch request while the credit count of its output port and output VC is zero. One returned credit lets exactly one more flit go.
- R6: When a flit with tail bit set traverses, vc_free_o pulses together with it. The input VC returns to idle, so a later head on it requests VC allocation again.
- R7: A head queued behind an unfinished packet on the same VC raises no VC allocation request until that packet's tail has traversed.
- R8: A switch request that is not granted keeps being presented in following cycles with no flit forwarded. Every forwarded flit follows a cycle with a granted request.
- R9: Output ports are one-hot: bit 0 local, bit 1 east (+x), bit 2 west (-x), bit 3 north (+y), bit 4 south (-y). X is resolved before Y. The credit index of a pair is port_bit_number*NUM_VC + output_vc.
- R10: Each credit counter resets to DS_DEPTH. It falls by one per forwarded flit, rises by one per credit_ret_i pulse, and never exceeds DS_DEPTH; returns arriving while full are dropped.
- R11: After reset no VC or switch request is raised and the crossbar output is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flit_valid_i | input | 1 | Incoming flit valid |
| flit_vc_i | input | VCID_W | Input VC of the flit |
| flit_type_i | input | 2 | Flit type (R2) |
| flit_dst_x_i | input | COORD_W | Destination x coordinate |
| flit_dst_y_i | input | COORD_W | Destination y coordinate |
| flit_data_i | input | DATA_W | Flit payload |
| va_req_o | output | NUM_VC | Per-VC request to the VC allocator |
| va_port_o | output | NUM_VC x 5 | Requested output port per VC |
| va_gnt_i | input | NUM_VC | Per-VC VC allocation grant |
| va_ovc_i | input | NUM_VC x VCID_W | Allocated output VC per VC |
| sa_req_o | output | NUM_VC | Per-VC request to the switch allocator |
| sa_port_o | output | NUM_VC x 5 | Requested output port per VC |
| sa_gnt_i | input | NUM_VC | Per-VC switch grant |
| credit_ret_i | input | 5*NUM_VC | Credit return pulses per output port and VC |
| xbar_valid_o | output | 1 | Flit in traversal stage |
| xbar_port_o | output | 5 | One-hot output port |
| xbar_ovc_o | output | VCID_W | Output VC |
| xbar_type_o | output | 2 | Flit type |
| xbar_dst_x_o | output | COORD_W | Destination x |
| xbar_dst_y_o | output | COORD_W | Destination y |
| xbar_data_o | output | DATA_W | Payload |
| vc_free_o | output | 1 | Downstream VC release, with the tail flit |

## Verification
The bench builds the unit with two virtual channels, four-entry queues, a downstream depth of two and the router at coordinate (2,2). A downstream depth of two lets a three-flit packet run out of credits, so credit stalls, single-credit release and the cap on surplus returns can be observed. Two channels allow interleaved packets and a swapped output-VC mapping. The centre position makes all five output directions reachable.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int NPORT   = 5;
  localparam int P_LOCAL = 0;
  localparam int P_EAST  = 1;
  localparam int P_WEST  = 2;
  localparam int P_NORTH = 3;
  localparam int P_SOUTH = 4;

  typedef enum logic [1:0] {
    VS_IDLE = 2'd0,
    VS_VA   = 2'd1,
    VS_ACT  = 2'd2
  } vc_state_e;

  function automatic logic [2:0] port_bin(input logic [NPORT-1:0] oh);
    logic [2:0] b;
    b = '0;
    for (int i = 0; i < NPORT; i++)
      if (oh[i]) b = 3'(i);
    return b;
  endfunction
endpackage

// File: rtl/vcr_fifo.sv
module vcr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  output logic [W-1:0] rdata_o,
  output logic         valid_o,
  output logic         full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  assign valid_o = cnt != '0;
  assign full_o  = cnt == CW'(DEPTH);
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_i && !full_o) wptr <= nxt(wptr);
      if (rd_i && valid_o) rptr <= nxt(rptr);
      case ({wr_i && !full_o, rd_i && valid_o})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i)
    if (wr_i && !full_o) mem[wptr] <= wdata_i;
endmodule

// File: rtl/vcr_route_xy.sv
module vcr_route_xy
  import vcr_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int MY_X    = 0,
  parameter int MY_Y    = 0
) (
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  output logic [NPORT-1:0]   port_o
);
  always_comb begin
    port_o = '0;
    if (dst_x_i > COORD_W'(MY_X))      port_o[P_EAST]  = 1'b1;
    else if (dst_x_i < COORD_W'(MY_X)) port_o[P_WEST]  = 1'b1;
    else if (dst_y_i > COORD_W'(MY_Y)) port_o[P_NORTH] = 1'b1;
    else if (dst_y_i < COORD_W'(MY_Y)) port_o[P_SOUTH] = 1'b1;
    else                               port_o[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/vcr_vc_ctrl.sv
module vcr_vc_ctrl
  import vcr_pkg::*;
#(
  parameter int COORD_W = 3,
  parameter int MY_X    = 0,
  parameter int MY_Y    = 0,
  parameter int VCID_W  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               front_valid_i,
  input  logic [1:0]         front_type_i,
  input  logic [COORD_W-1:0] front_dst_x_i,
  input  logic [COORD_W-1:0] front_dst_y_i,
  input  logic               va_gnt_i,
  input  logic [VCID_W-1:0]  va_ovc_i,
  input  logic               cred_ok_i,
  input  logic               sa_gnt_i,
  output logic               va_req_o,
  output logic               sa_req_o,
  output logic [NPORT-1:0]   route_o,
  output logic [VCID_W-1:0]  ovc_o,
  output logic               send_o,
  output logic               pop_o
);
  vc_state_e          state_q;
  logic [NPORT-1:0]   rc_port;
  logic               drop;

  vcr_route_xy #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_rc (
    .dst_x_i (front_dst_x_i),
    .dst_y_i (front_dst_y_i),
    .port_o  (rc_port)
  );

  assign va_req_o = state_q == VS_VA;
  assign sa_req_o = (state_q == VS_ACT) && front_valid_i && cred_ok_i;
  assign send_o   = sa_req_o && sa_gnt_i;
  // non-head flit at front of an idle VC has no packet: discard it
  assign drop     = (state_q == VS_IDLE) && front_valid_i && !front_type_i[0];
  assign pop_o    = send_o || drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= VS_IDLE;
      route_o <= '0;
      ovc_o   <= '0;
    end else begin
      case (state_q)
        VS_IDLE: if (front_valid_i && front_type_i[0]) begin
          route_o <= rc_port;
          state_q <= VS_VA;
        end
        VS_VA: if (va_gnt_i) begin
          ovc_o   <= va_ovc_i;
          state_q <= VS_ACT;
        end
        VS_ACT: if (send_o && front_type_i[1]) state_q <= VS_IDLE;
        default: state_q <= VS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcr_credits.sv
module vcr_credits #(
  parameter int N        = 10,
  parameter int DS_DEPTH = 4,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1,
  localparam int CW      = $clog2(DS_DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  dec_i,
  input  logic [IDX_W-1:0]      dec_idx_i,
  input  logic [N-1:0]          ret_i,
  output logic [N-1:0][CW-1:0]  cnt_o
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic       hit;
    logic [CW:0] sum;
    assign hit = dec_i && (dec_idx_i == IDX_W'(i));
    always_comb begin
      sum = {1'b0, cnt_o[i]} + (CW+1)'(ret_i[i]) - (CW+1)'(hit);
      if (sum > (CW+1)'(DS_DEPTH)) sum = (CW+1)'(DS_DEPTH);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_o[i] <= CW'(DS_DEPTH);
      else         cnt_o[i] <= sum[CW-1:0];
    end
  end
endmodule

// File: rtl/vc_input_unit.sv
module vc_input_unit
  import vcr_pkg::*;
#(
  parameter int NUM_VC     = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int DS_DEPTH   = 4,
  parameter int COORD_W    = 3,
  parameter int DATA_W     = 16,
  parameter int MY_X       = 0,
  parameter int MY_Y       = 0,
  localparam int VCID_W    = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             flit_valid_i,
  input  logic [VCID_W-1:0]                flit_vc_i,
  input  logic [1:0]                       flit_type_i,
  input  logic [COORD_W-1:0]               flit_dst_x_i,
  input  logic [COORD_W-1:0]               flit_dst_y_i,
  input  logic [DATA_W-1:0]                flit_data_i,
  output logic [NUM_VC-1:0]                va_req_o,
  output logic [NUM_VC-1:0][4:0]           va_port_o,
  input  logic [NUM_VC-1:0]                va_gnt_i,
  input  logic [NUM_VC-1:0][VCID_W-1:0]    va_ovc_i,
  output logic [NUM_VC-1:0]                sa_req_o,
  output logic [NUM_VC-1:0][4:0]           sa_port_o,
  input  logic [NUM_VC-1:0]                sa_gnt_i,
  input  logic [5*NUM_VC-1:0]              credit_ret_i,
  output logic                             xbar_valid_o,
  output logic [4:0]                       xbar_port_o,
  output logic [VCID_W-1:0]                xbar_ovc_o,
  output logic [1:0]                       xbar_type_o,
  output logic [COORD_W-1:0]               xbar_dst_x_o,
  output logic [COORD_W-1:0]               xbar_dst_y_o,
  output logic [DATA_W-1:0]                xbar_data_o,
  output logic                             vc_free_o
);
  localparam int FW    = 2 + 2*COORD_W + DATA_W;
  localparam int NCRED = NPORT * NUM_VC;
  localparam int IDX_W = (NCRED > 1) ? $clog2(NCRED) : 1;
  localparam int CW    = $clog2(DS_DEPTH + 1);
  localparam logic [NUM_VC-1:0] ONE_VC = 1;

  logic [FW-1:0]           front [NUM_VC];
  logic [NUM_VC-1:0]       front_v, pop, send, cred_ok;
  logic [NPORT-1:0]        route [NUM_VC];
  logic [VCID_W-1:0]       ovc   [NUM_VC];
  logic [IDX_W-1:0]        cidx  [NUM_VC];
  logic [NCRED-1:0][CW-1:0] cred_cnt;
  logic [NUM_VC-1:0]       sa_want, sa_pick;

  assign sa_want = sa_req_o & sa_gnt_i;
  assign sa_pick = sa_want & (~sa_want + ONE_VC);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic wr;
    logic full_unused;
    assign wr = flit_valid_i && (flit_vc_i == VCID_W'(v));

    vcr_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr),
      .wdata_i ({flit_type_i, flit_dst_x_i, flit_dst_y_i, flit_data_i}),
      .rd_i    (pop[v]),
      .rdata_o (front[v]),
      .valid_o (front_v[v]),
      .full_o  (full_unused)
    );

    vcr_vc_ctrl #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y), .VCID_W(VCID_W)) u_ctrl (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .front_valid_i (front_v[v]),
      .front_type_i  (front[v][FW-1 -: 2]),
      .front_dst_x_i (front[v][DATA_W+COORD_W +: COORD_W]),
      .front_dst_y_i (front[v][DATA_W +: COORD_W]),
      .va_gnt_i      (va_gnt_i[v]),
      .va_ovc_i      (va_ovc_i[v]),
      .cred_ok_i     (cred_ok[v]),
      .sa_gnt_i      (sa_pick[v]),
      .va_req_o      (va_req_o[v]),
      .sa_req_o      (sa_req_o[v]),
      .route_o       (route[v]),
      .ovc_o         (ovc[v]),
      .send_o        (send[v]),
      .pop_o         (pop[v])
    );

    assign cidx[v]      = IDX_W'(int'(port_bin(route[v])) * NUM_VC + int'(ovc[v]));
    assign cred_ok[v]   = cred_cnt[cidx[v]] != '0;
    assign va_port_o[v] = route[v];
    assign sa_port_o[v] = route[v];
  end

  // traversal stage select
  logic [FW-1:0]      st_flit;
  logic [NPORT-1:0]   st_port;
  logic [VCID_W-1:0]  st_ovc;
  logic [IDX_W-1:0]   st_idx;

  always_comb begin
    st_flit = '0;
    st_port = '0;
    st_ovc  = '0;
    st_idx  = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (sa_pick[v]) begin
        st_flit = front[v];
        st_port = route[v];
        st_ovc  = ovc[v];
        st_idx  = cidx[v];
      end
    end
  end

  vcr_credits #(.N(NCRED), .DS_DEPTH(DS_DEPTH)) u_cred (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dec_i     (|send),
    .dec_idx_i (st_idx),
    .ret_i     (credit_ret_i),
    .cnt_o     (cred_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xbar_valid_o <= 1'b0;
      xbar_port_o  <= '0;
      xbar_ovc_o   <= '0;
      xbar_type_o  <= '0;
      xbar_dst_x_o <= '0;
      xbar_dst_y_o <= '0;
      xbar_data_o  <= '0;
      vc_free_o    <= 1'b0;
    end else begin
      xbar_valid_o <= |sa_pick;
      vc_free_o    <= (|sa_pick) && st_flit[FW-1];
      if (|sa_pick) begin
        xbar_port_o  <= st_port;
        xbar_ovc_o   <= st_ovc;
        xbar_type_o  <= st_flit[FW-1 -: 2];
        xbar_dst_x_o <= st_flit[DATA_W+COORD_W +: COORD_W];
        xbar_dst_y_o <= st_flit[DATA_W +: COORD_W];
        xbar_data_o  <= st_flit[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vc_input_unit_chk.sv
module vc_input_unit_chk #(
  parameter int NUM_VC   = 2,
  parameter int DS_DEPTH = 4,
  parameter int NCRED    = 10,
  parameter int CW       = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_VC-1:0]           va_req_o,
  input logic [NUM_VC-1:0]           sa_req_o,
  input logic [NUM_VC-1:0]           sa_gnt_i,
  input logic                        xbar_valid_o,
  input logic [4:0]                  xbar_port_o,
  input logic [1:0]                  xbar_type_o,
  input logic                        vc_free_o,
  input logic [NCRED-1:0][CW-1:0]    cred_cnt
);
  AST_VA_SA_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (va_req_o & sa_req_o) == '0); // R4

  AST_ST_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xbar_valid_o |-> $past(|(sa_req_o & sa_gnt_i))); // R8

  AST_PORT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xbar_valid_o |-> $countones(xbar_port_o) == 1); // R9

  AST_FREE_ON_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vc_free_o |-> (xbar_valid_o && xbar_type_o[1])); // R6

  always_ff @(posedge clk_i) begin
    if (rst_ni) begin
      for (int i = 0; i < NCRED; i++)
        AST_CREDIT_CAP: assert (int'(cred_cnt[i]) <= DS_DEPTH); // R10
    end
  end
endmodule

bind vc_input_unit vc_input_unit_chk #(
  .NUM_VC(NUM_VC), .DS_DEPTH(DS_DEPTH), .NCRED(NCRED), .CW(CW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .va_req_o     (va_req_o),
  .sa_req_o     (sa_req_o),
  .sa_gnt_i     (sa_gnt_i),
  .xbar_valid_o (xbar_valid_o),
  .xbar_port_o  (xbar_port_o),
  .xbar_type_o  (xbar_type_o),
  .vc_free_o    (vc_free_o),
  .cred_cnt     (cred_cnt)
);

// File: tb/vc_input_unit_test.sv
`timescale 1ns/1ps
module vc_input_unit_test;
  localparam int NV = 2;
  localparam int CWD = 3;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            flit_valid_i = 1'b0;
  logic [0:0]      flit_vc_i = '0;
  logic [1:0]      flit_type_i = '0;
  logic [CWD-1:0]  flit_dst_x_i = '0, flit_dst_y_i = '0;
  logic [DW-1:0]   flit_data_i = '0;
  logic [NV-1:0]   va_req_o, sa_req_o;
  logic [NV-1:0][4:0] va_port_o, sa_port_o;
  logic [NV-1:0]   va_gnt_i = '0, sa_gnt_i = '0;
  logic [NV-1:0][0:0] va_ovc_i = '0;
  logic [5*NV-1:0] credit_ret_i = '0;
  logic            xbar_valid_o, vc_free_o;
  logic [4:0]      xbar_port_o;
  logic [0:0]      xbar_ovc_o;
  logic [1:0]      xbar_type_o;
  logic [CWD-1:0]  xbar_dst_x_o, xbar_dst_y_o;
  logic [DW-1:0]   xbar_data_o;

  vc_input_unit #(.NUM_VC(NV), .FIFO_DEPTH(4), .DS_DEPTH(2), .COORD_W(CWD),
                  .DATA_W(DW), .MY_X(2), .MY_Y(2)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .flit_valid_i, .flit_vc_i, .flit_type_i, .flit_dst_x_i, .flit_dst_y_i, .flit_data_i,
    .va_req_o, .va_port_o, .va_gnt_i, .va_ovc_i,
    .sa_req_o, .sa_port_o, .sa_gnt_i, .credit_ret_i,
    .xbar_valid_o, .xbar_port_o, .xbar_ovc_o, .xbar_type_o,
    .xbar_dst_x_o, .xbar_dst_y_o, .xbar_data_o, .vc_free_o
  );

  int total = 0, bad = 0;
  bit done = 0;

  // allocator model and scoreboard state
  logic [15:0] q0 [$];
  logic [15:0] q1 [$];
  logic [0:0]  map0 = 1'b0, map1 = 1'b1;
  logic [NV-1:0] va_hold = '0, sa_hold = '0;
  logic [5*NV-1:0] pend = '0, man_ret = '0;
  bit auto_credit = 1;
  int va_seen0 = 0;
  logic [NV-1:0] want;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] xy_port(input logic [CWD-1:0] dx, input logic [CWD-1:0] dy);
    if (dx > 3'd2) return 5'b00010;
    if (dx < 3'd2) return 5'b00100;
    if (dy > 3'd2) return 5'b01000;
    if (dy < 3'd2) return 5'b10000;
    return 5'b00001;
  endfunction

  function automatic int pbin(input logic [4:0] p);
    int b = 0;
    for (int i = 0; i < 5; i++) if (p[i]) b = i;
    return b;
  endfunction

  task automatic check_item(input logic [15:0] e);
    chk(xbar_port_o == e[15:11], "R9 port", int'(xbar_port_o), int'(e[15:11]));
    chk({xbar_ovc_o, xbar_type_o, xbar_data_o} == e[10:0], "R3 order/content",
        int'({xbar_ovc_o, xbar_type_o, xbar_data_o}), int'(e[10:0]));
    chk(vc_free_o == e[9], "R6 release", int'(vc_free_o), int'(e[9]));
  endtask

  always @(negedge clk) begin
    credit_ret_i = pend | man_ret;
    pend = '0;
    man_ret = '0;
    if (rst_n) begin
      va_seen0 += int'(va_req_o[0]);
      if (xbar_valid_o) begin
        if (xbar_ovc_o == map0 && q0.size() > 0) check_item(q0.pop_front());
        else if (xbar_ovc_o == map1 && q1.size() > 0) check_item(q1.pop_front());
        else chk(0, "R3 unexpected flit", int'(xbar_data_o), -1);
        if (auto_credit) pend[pbin(xbar_port_o)*NV + int'(xbar_ovc_o)] = 1'b1;
      end
    end
    va_gnt_i[0] = va_req_o[0] && !va_hold[0];
    va_gnt_i[1] = va_req_o[1] && !va_hold[1];
    va_ovc_i[0] = map0;
    va_ovc_i[1] = map1;
    want = sa_req_o & ~sa_hold;
    sa_gnt_i = want & (~want + 2'b01);
  end

  task automatic send(input int vc, input logic [1:0] t, input logic [CWD-1:0] dx,
                      input logic [CWD-1:0] dy, input logic [DW-1:0] d);
    logic [0:0] o;
    o = (vc == 0) ? map0 : map1;
    if (vc == 0) q0.push_back({xy_port(dx, dy), o, t, d});
    else         q1.push_back({xy_port(dx, dy), o, t, d});
    flit_valid_i = 1'b1;
    flit_vc_i    = 1'(vc);
    flit_type_i  = t;
    flit_dst_x_i = dx;
    flit_dst_y_i = dy;
    flit_data_i  = d;
    @(negedge clk);
    flit_valid_i = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 80 && (q0.size() + q1.size()) > 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q0.size() + q1.size() == 0, req, q0.size() + q1.size(), 0);
  endtask

  task automatic ret_credit(input int idx);
    man_ret[idx] = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(xbar_valid_o == 0, "R11 xbar idle", int'(xbar_valid_o), 0);
    chk(va_req_o == 0, "R11 no va req", int'(va_req_o), 0);
    chk(sa_req_o == 0, "R11 no sa req", int'(sa_req_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: single-flit packet, stage timing
    send(0, 2'b11, 3'd3, 3'd2, 8'h11);
    chk(va_req_o[0] == 0 && sa_req_o[0] == 0, "R1 cycle1 routing", int'({va_req_o[0], sa_req_o[0]}), 0);
    @(negedge clk);
    chk(va_req_o[0] == 1 && sa_req_o[0] == 0, "R1 cycle2 va", int'({va_req_o[0], sa_req_o[0]}), 2);
    @(negedge clk);
    chk(va_req_o[0] == 0 && sa_req_o[0] == 1, "R1 cycle3 sa", int'({va_req_o[0], sa_req_o[0]}), 1);
    @(negedge clk);
    chk(xbar_valid_o == 1, "R1 cycle4 traversal", int'(xbar_valid_o), 1);
    @(negedge clk);
    chk(va_req_o[0] == 0 && sa_req_o[0] == 0, "R6 back to idle", int'({va_req_o[0], sa_req_o[0]}), 0);
    drain("R1 drain");

    // R2: multi-flit packet, only head does VA
    va_seen0 = 0;
    send(0, 2'b01, 3'd0, 3'd2, 8'h20);
    send(0, 2'b00, 3'd0, 3'd2, 8'h21);
    send(0, 2'b00, 3'd0, 3'd2, 8'h22);
    send(0, 2'b10, 3'd0, 3'd2, 8'h23);
    drain("R2 drain");
    chk(va_seen0 == 1, "R2 single va request", va_seen0, 1);

    // R4: VA withheld
    va_hold[1] = 1'b1;
    send(1, 2'b11, 3'd2, 3'd5, 8'h40);
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(va_req_o[1] == 1 && sa_req_o[1] == 0 && xbar_valid_o == 0, "R4 hold in va",
          int'({va_req_o[1], sa_req_o[1], xbar_valid_o}), 4);
    end
    va_hold[1] = 1'b0;
    drain("R4 drain");

    // R8: SA withheld, retry
    sa_hold[0] = 1'b1;
    send(0, 2'b11, 3'd2, 3'd0, 8'h80);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(sa_req_o[0] == 1 && xbar_valid_o == 0, "R8 retry request",
          int'({sa_req_o[0], xbar_valid_o}), 2);
    end
    sa_hold[0] = 1'b0;
    drain("R8 drain");

    // R5: credit exhaustion on east/ovc0 (index 1*2+0=2)
    repeat (4) @(negedge clk);
    auto_credit = 0;
    send(0, 2'b01, 3'd5, 3'd1, 8'h50);
    send(0, 2'b00, 3'd5, 3'd1, 8'h51);
    send(0, 2'b10, 3'd5, 3'd1, 8'h52);
    repeat (12) @(negedge clk);
    chk(q0.size() == 1, "R5 stall at zero credit", q0.size(), 1);
    chk(sa_req_o[0] == 0, "R5 no sa request", int'(sa_req_o[0]), 0);
    ret_credit(2);
    drain("R5 one credit releases one flit");

    // R10: surplus returns are capped at DS_DEPTH
    for (int i = 0; i < 4; i++) ret_credit(2);
    send(0, 2'b01, 3'd5, 3'd1, 8'h60);
    send(0, 2'b00, 3'd5, 3'd1, 8'h61);
    send(0, 2'b10, 3'd5, 3'd1, 8'h62);
    repeat (12) @(negedge clk);
    chk(q0.size() == 1, "R10 credit cap", q0.size(), 1);
    ret_credit(2);
    drain("R10 drain");
    ret_credit(2);
    ret_credit(2);
    auto_credit = 1;

    // R7: new head waits behind pending tail
    va_seen0 = 0;
    sa_hold[0] = 1'b1;
    send(0, 2'b01, 3'd1, 3'd2, 8'h70);
    send(0, 2'b10, 3'd1, 3'd2, 8'h71);
    send(0, 2'b11, 3'd2, 3'd6, 8'h72);
    repeat (8) @(negedge clk);
    chk(va_seen0 == 1, "R7 second head waits", va_seen0, 1);
    chk(va_req_o[0] == 0, "R7 no va while packet open", int'(va_req_o[0]), 0);
    sa_hold[0] = 1'b0;
    drain("R7 drain");
    chk(va_seen0 == 2, "R6 next head reallocates", va_seen0, 2);

    // R3: interleaved packets on two VCs
    send(0, 2'b01, 3'd4, 3'd2, 8'h90);
    send(1, 2'b01, 3'd2, 3'd4, 8'hA0);
    send(0, 2'b00, 3'd4, 3'd2, 8'h91);
    send(1, 2'b00, 3'd2, 3'd4, 8'hA1);
    send(0, 2'b10, 3'd4, 3'd2, 8'h92);
    send(1, 2'b10, 3'd2, 3'd4, 8'hA2);
    drain("R3 interleave drain");

    // R9: all directions, swapped output VC mapping
    map0 = 1'b1;
    map1 = 1'b0;
    send(0, 2'b11, 3'd2, 3'd2, 8'hB0);
    send(1, 2'b11, 3'd0, 3'd0, 8'hB1);
    send(0, 2'b11, 3'd4, 3'd4, 8'hB2);
    send(1, 2'b11, 3'd2, 3'd7, 8'hB3);
    send(0, 2'b11, 3'd2, 3'd1, 8'hB4);
    drain("R9 drain");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule